// File: doc/BRIEF.md
# Host-Port Bus Write Sequencer

This block performs a single write access on a parallel host-port bus to an external signal processor. A start request captures an address, a write data word and five phase lengths. The access then runs through five phases in a fixed order: address, data setup, data strobe, hold and recovery. Each phase lasts its programmed length plus one bus clock. Lengths below a legal floor are raised to that floor when the access starts.

The external device can stretch the access with an active-high wait input. While wait is high, the sequencer stays in the address phase or the strobe phase. The stalled phase always runs at least one more clock after wait falls. The chip select (active low) and the address are driven together from the first address clock through the end of hold. Write data is driven from setup through hold. The data strobe (active low) is low for the strobe phase only. A one-clock done pulse marks the last recovery clock, so the recovery length sets the idle gap before the next access.

Top module: `hostwr_seq`

## Requirements
- R1: After reset and between accesses, busy and done are 0, chipSelN and strobeN are 1, and addrBus and dataBus are 0.
- R2: A start request seen while idle begins the address phase on the next clock. The phases then follow in the order address, setup, strobe, hold, recovery. Each phase lasts (its length input + 1) clocks, where the lengths are addrLen, setupLen, strobeLen, holdLen and recoverLen.
- R3: When an access starts, addrLen and setupLen values below 2 are used as 2, and a strobeLen value below 1 is used as 1. Hold and recovery have a floor of 0.
- R4: In the address or strobe phase, the phase does not end in any clock where extWait is 1. The phase ends at the earliest clock, at or after its nominal last clock, in which extWait is 0.
- R5: extWait has no effect during the setup, hold and recovery phases.
- R6: chipSelN is 0 and addrBus carries the captured address from the first address clock through the last hold clock. Outside that window, chipSelN is 1 and addrBus is 0.
- R7: dataBus carries the captured write data from the first setup clock through the last hold clock, and is 0 otherwise.
- R8: strobeN is 0 exactly during the strobe phase.
- R9: busy is 1 from the first address clock through the last recovery clock. done is 1 only in the last recovery clock. The clock after done is idle and can accept a new start.
- R10: startReq is ignored while busy. Changes to the address, data and length inputs during an access do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request one write access (used only when idle) |
| extWait | input | 1 | Wait from the external device, active high |
| addrIn | input | ADDR_W | Address to write |
| dataIn | input | DATA_W | Data to write |
| addrLen | input | CNT_W | Address phase length minus one |
| setupLen | input | CNT_W | Setup phase length minus one |
| strobeLen | input | CNT_W | Strobe phase length minus one |
| holdLen | input | CNT_W | Hold phase length minus one |
| recoverLen | input | CNT_W | Recovery phase length minus one |
| addrBus | output | ADDR_W | Address bus |
| dataBus | output | DATA_W | Data bus |
| chipSelN | output | 1 | Chip select, active low |
| strobeN | output | 1 | Data strobe, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last clock of the recovery phase |

## Verification
The bench uses the default parameters: 16-bit address and data, 4-bit lengths, and floors of 2, 2, 1, 0, 0. With 4-bit lengths, both the clamped bottom of each range and the top value of 15 (16 clocks per phase) are exercised in short runs. Wait windows are placed before, across and after the nominal end of the address and strobe phases, and also inside the phases that ignore wait. Accesses run back to back, with start held high and all inputs changed while busy.

// File: rtl/hostwr_pkg.sv
package hostwr_pkg;
  localparam int NUM_PHASES = 5;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4,
    PH_RECOV  = 3'd5
  } phase_t;

  typedef struct packed {
    logic       capture;
    logic       advance;
    logic [2:0] nextIdx;
    logic       addrEn;
    logic       dataEn;
    logic       csAct;
    logic       strbAct;
  } ctrlStrobes_t;
endpackage

// File: rtl/hostwr_ctrl.sv
module hostwr_ctrl
  import hostwr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         extWait,
  input  logic         cntZero,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  phase_t phase, phaseNext;
  logic   waitable;
  logic   leave;

  assign waitable = (phase == PH_ADDR) || (phase == PH_STROBE);
  assign busy     = (phase != PH_IDLE);
  assign leave    = busy && cntZero && !(waitable && extWait);
  assign done     = (phase == PH_RECOV) && cntZero;

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:   if (startReq) phaseNext = PH_ADDR;
      PH_ADDR:   if (leave) phaseNext = PH_SETUP;
      PH_SETUP:  if (leave) phaseNext = PH_STROBE;
      PH_STROBE: if (leave) phaseNext = PH_HOLD;
      PH_HOLD:   if (leave) phaseNext = PH_RECOV;
      PH_RECOV:  if (leave) phaseNext = PH_IDLE;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobes.capture = (phase == PH_IDLE) && startReq;
    strobes.advance = leave;
    case (phase)
      PH_ADDR:   strobes.nextIdx = 3'd1;
      PH_SETUP:  strobes.nextIdx = 3'd2;
      PH_STROBE: strobes.nextIdx = 3'd3;
      PH_HOLD:   strobes.nextIdx = 3'd4;
      default:   strobes.nextIdx = 3'd0;
    endcase
    strobes.csAct   = (phase == PH_ADDR) || (phase == PH_SETUP) ||
                      (phase == PH_STROBE) || (phase == PH_HOLD);
    strobes.addrEn  = strobes.csAct;
    strobes.dataEn  = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                      (phase == PH_HOLD);
    strobes.strbAct = (phase == PH_STROBE);
  end

  AST_WAIT_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ADDR && extWait) |=> (phase == PH_ADDR)); // R4
  AST_WAIT_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE && extWait) |=> (phase == PH_STROBE)); // R4
  AST_SETUP_TO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SETUP) |=> (phase == PH_SETUP || phase == PH_STROBE)); // R2
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (phase == PH_IDLE)); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy); // R10
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> (phase == PH_ADDR)); // R2
endmodule

// File: rtl/hostwr_dpath.sv
module hostwr_dpath
  import hostwr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 4,
  parameter int MIN_ADDR   = 2,
  parameter int MIN_SETUP  = 2,
  parameter int MIN_STROBE = 1,
  parameter int MIN_HOLD   = 0,
  parameter int MIN_RECOV  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  addrLen,
  input  logic [CNT_W-1:0]  setupLen,
  input  logic [CNT_W-1:0]  strobeLen,
  input  logic [CNT_W-1:0]  holdLen,
  input  logic [CNT_W-1:0]  recoverLen,
  output logic              cntZero,
  output logic [ADDR_W-1:0] addrBus,
  output logic [DATA_W-1:0] dataBus,
  output logic              chipSelN,
  output logic              strobeN
);
  localparam logic [NUM_PHASES-1:0][CNT_W-1:0] MIN_VEC = {
    CNT_W'(MIN_RECOV), CNT_W'(MIN_HOLD), CNT_W'(MIN_STROBE),
    CNT_W'(MIN_SETUP), CNT_W'(MIN_ADDR)
  };

  logic [NUM_PHASES-1:0][CNT_W-1:0] lenRaw;
  logic [NUM_PHASES-1:0][CNT_W-1:0] lenClamp;
  logic [NUM_PHASES-1:0][CNT_W-1:0] lenQ;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  assign lenRaw = {recoverLen, holdLen, strobeLen, setupLen, addrLen};

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_clamp
    assign lenClamp[k] = (lenRaw[k] < MIN_VEC[k]) ? MIN_VEC[k] : lenRaw[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ  <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobes.capture) begin
      lenQ  <= lenClamp;
      addrQ <= addrIn;
      dataQ <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobes.capture) cnt <= lenClamp[0];
    else if (strobes.advance) cnt <= lenQ[strobes.nextIdx];
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign cntZero  = (cnt == '0);
  assign addrBus  = strobes.addrEn ? addrQ : '0;
  assign dataBus  = strobes.dataEn ? dataQ : '0;
  assign chipSelN = !strobes.csAct;
  assign strobeN  = !strobes.strbAct;

  AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> !chipSelN); // R8
  AST_CLAMP_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (cnt >= MIN_VEC[0])); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.addrEn && $past(strobes.addrEn)) |-> $stable(addrBus)); // R6
  AST_DATA_IN_CS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dataEn |-> !chipSelN); // R7
endmodule

// File: rtl/hostwr_seq.sv
module hostwr_seq
  import hostwr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 4,
  parameter int MIN_ADDR   = 2,
  parameter int MIN_SETUP  = 2,
  parameter int MIN_STROBE = 1,
  parameter int MIN_HOLD   = 0,
  parameter int MIN_RECOV  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              extWait,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  addrLen,
  input  logic [CNT_W-1:0]  setupLen,
  input  logic [CNT_W-1:0]  strobeLen,
  input  logic [CNT_W-1:0]  holdLen,
  input  logic [CNT_W-1:0]  recoverLen,
  output logic [ADDR_W-1:0] addrBus,
  output logic [DATA_W-1:0] dataBus,
  output logic              chipSelN,
  output logic              strobeN,
  output logic              busy,
  output logic              done
);
  ctrlStrobes_t strobes;
  logic         cntZero;

  hostwr_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .extWait  (extWait),
    .cntZero  (cntZero),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  hostwr_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .MIN_ADDR   (MIN_ADDR),
    .MIN_SETUP  (MIN_SETUP),
    .MIN_STROBE (MIN_STROBE),
    .MIN_HOLD   (MIN_HOLD),
    .MIN_RECOV  (MIN_RECOV)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .addrIn     (addrIn),
    .dataIn     (dataIn),
    .addrLen    (addrLen),
    .setupLen   (setupLen),
    .strobeLen  (strobeLen),
    .holdLen    (holdLen),
    .recoverLen (recoverLen),
    .cntZero    (cntZero),
    .addrBus    (addrBus),
    .dataBus    (dataBus),
    .chipSelN   (chipSelN),
    .strobeN    (strobeN)
  );
endmodule

// File: tb/test_hostwr_seq.sv
`timescale 1ns/1ps
module test_hostwr_seq;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic extWait = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic [CW-1:0] addrLen = '0, setupLen = '0, strobeLen = '0, holdLen = '0, recoverLen = '0;
  logic [AW-1:0] addrBus;
  logic [DW-1:0] dataBus;
  logic chipSelN, strobeN, busy, done;

  always #4 clk = ~clk;

  hostwr_seq i_hostwr_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .extWait(extWait),
    .addrIn(addrIn), .dataIn(dataIn), .addrLen(addrLen), .setupLen(setupLen),
    .strobeLen(strobeLen), .holdLen(holdLen), .recoverLen(recoverLen),
    .addrBus(addrBus), .dataBus(dataBus), .chipSelN(chipSelN),
    .strobeN(strobeN), .busy(busy), .done(done)
  );

  typedef struct {
    logic          busy;
    logic          csN;
    logic          strbN;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          done;
    string         tag;
  } item_t;

  item_t expQ[$];
  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  function automatic item_t idleItem(string tag);
    item_t it;
    it.busy = 0; it.csN = 1; it.strbN = 1; it.addr = '0; it.data = '0; it.done = 0;
    it.tag = tag;
    return it;
  endfunction

  function automatic int floorOf(int k);
    case (k)
      0: return 2;
      1: return 2;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic compareNow(item_t e);
    vectors++;
    if (busy !== e.busy || chipSelN !== e.csN || strobeN !== e.strbN ||
        addrBus !== e.addr || dataBus !== e.data || done !== e.done) begin
      fails++;
      $display("FAIL %s: got busy=%b cs=%b strb=%b addr=%h data=%h done=%b exp busy=%b cs=%b strb=%b addr=%h data=%h done=%b",
               e.tag, busy, chipSelN, strobeN, addrBus, dataBus, done,
               e.busy, e.csN, e.strbN, e.addr, e.data, e.done);
    end
  endtask

  // Monitor: mid-cycle compare against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) compareNow(expQ.pop_front());
    end
  end

  task automatic idleCycles(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      startReq = 0; extWait = 0;
      expQ.push_back(idleItem(tag));
    end
  endtask

  // Driver: one access with an optional wait window in phase wPh (0..4, -1 none)
  task automatic doAccess(logic [AW-1:0] a, logic [DW-1:0] d,
                          int p0, int p1, int p2, int p3, int p4,
                          int wPh, int wOff, int wLen, bit busyStart,
                          bit scramble, string tag);
    int p[5];
    int len[5];
    item_t it;
    p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3; p[4] = p4;
    @(posedge clk); #1;
    addrIn = a; dataIn = d;
    addrLen = CW'(p0); setupLen = CW'(p1); strobeLen = CW'(p2);
    holdLen = CW'(p3); recoverLen = CW'(p4);
    startReq = 1; extWait = 0;
    expQ.push_back(idleItem(tag));
    for (int k = 0; k < 5; k++) begin
      int n;
      n = ((p[k] < floorOf(k)) ? floorOf(k) : p[k]) + 1;
      if (wPh == k && (k == 0 || k == 2)) begin
        int e;
        e = n - 1;
        while (e >= wOff && e < wOff + wLen) e++;
        n = e + 1;
      end
      len[k] = n;
    end
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < len[k]; i++) begin
        @(posedge clk); #1;
        startReq = busyStart;
        extWait = (wPh == k && i >= wOff && i < wOff + wLen);
        if (scramble) begin
          addrIn = ~a; dataIn = ~d;
          addrLen = CW'(i); setupLen = '1; strobeLen = '0; holdLen = '1; recoverLen = CW'(k);
        end
        it.busy = 1;
        it.csN = (k <= 3) ? 1'b0 : 1'b1;
        it.strbN = (k == 2) ? 1'b0 : 1'b1;
        it.addr = (k <= 3) ? a : '0;
        it.data = (k >= 1 && k <= 3) ? d : '0;
        it.done = (k == 4 && i == len[k] - 1);
        it.tag = tag;
        expQ.push_back(it);
      end
    end
    startReq = 0; extWait = 0;
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        fails++;
        $display("FAIL watchdog: got cycles=%0d exp fewer than 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state while reset is held
    compareNow(idleItem("R1 reset"));
    rstN = 1;
    idleCycles(2, "R1 idle after reset");
    // R2 R6 R7 R8 R9: basic timing at floors
    doAccess(16'h1234, 16'hA5A5, 2, 2, 1, 0, 0, -1, 0, 0, 0, 0, "R2 basic");
    idleCycles(1, "R1 gap");
    // R2: longer phases
    doAccess(16'hBEEF, 16'h0F0F, 5, 3, 4, 2, 3, -1, 0, 0, 0, 0, "R2 long");
    // R2: top of range, back to back
    doAccess(16'hFFFF, 16'hFFFF, 15, 15, 15, 15, 15, -1, 0, 0, 0, 0, "R2 max R6 R7");
    // R3: below floors
    doAccess(16'h0001, 16'h8000, 0, 1, 0, 0, 0, -1, 0, 0, 0, 0, "R3 clamp");
    // R4: wait across end of address phase
    doAccess(16'h2222, 16'h3333, 2, 2, 1, 1, 1, 0, 1, 6, 0, 0, "R4 addr stretch");
    // R4: wait early in address phase, released before nominal end
    doAccess(16'h2223, 16'h3334, 4, 2, 1, 0, 0, 0, 0, 2, 0, 0, "R4 addr early");
    // R4: wait across end of strobe phase
    doAccess(16'h4444, 16'h5555, 2, 2, 1, 0, 0, 2, 1, 3, 0, 0, "R4 strobe stretch R8");
    // R4: wait after strobe nominal end in a longer strobe
    doAccess(16'h4445, 16'h5556, 2, 2, 3, 0, 0, 2, 3, 1, 0, 0, "R4 strobe last clock");
    // R5: wait in setup, hold, recovery ignored
    doAccess(16'h6666, 16'h7777, 2, 2, 1, 1, 1, 1, 0, 3, 0, 0, "R5 setup wait");
    doAccess(16'h6667, 16'h7778, 2, 2, 1, 2, 1, 3, 0, 3, 0, 0, "R5 hold wait");
    doAccess(16'h6668, 16'h7779, 2, 2, 1, 0, 2, 4, 0, 3, 0, 0, "R5 recover wait");
    // R10: start held during busy, inputs changed mid access
    doAccess(16'h9999, 16'hCCCC, 3, 2, 2, 1, 1, -1, 0, 0, 1, 1, "R10 ignore start");
    idleCycles(3, "R9 R1 idle after done");
    @(posedge clk); #6;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule